// File: doc/BRIEF.md
# Page-Mode ROM Burst Reader

This block turns host burst requests into read cycles on a parallel mask ROM that offers a fast in-page access mode. The host presents a start element address, a burst length and a byte/word selector with a single-cycle `req_valid` while `req_ready` is high. The controller then enables the ROM, walks consecutive addresses and returns one element per access on `rd_valid`/`rd_data`, flagging the final one with `rd_last`.

Each access holds the address on the ROM pins for a counted number of clock cycles before the data bus is captured. The first access of a burst, and any access whose address leaves the current 8-word page, uses the long (random-access) count. An access that only moves within the page uses the short count. In byte mode the ROM's top data pin becomes the lowest address input, so the controller drives it from bit 0 of the byte address and returns only the low data byte. When a burst ends, the ROM goes to standby and new requests are held off for a turnaround count, so the ROM's outputs can release before anything else drives the bus.

States: `ST_IDLE` (standby, ready for a request), `ST_ACCESS` (ROM enabled, one wait count per element) and `ST_RELEASE` (standby, counting turnaround). Transitions: `ST_IDLE`→`ST_ACCESS` on an accepted request. `ST_ACCESS`→`ST_ACCESS` after each non-final capture. `ST_ACCESS`→`ST_RELEASE` after the final capture when the turnaround count is non-zero, or `ST_ACCESS`→`ST_IDLE` when it is zero. `ST_RELEASE`→`ST_IDLE` when the turnaround count runs out.

Top module: `prom_page_reader`

## Requirements
- R1: After reset `rom_ce_n`=1, `rom_oe_n`=1, `req_ready`=1, `rd_valid`=0, `rom_byte_n`=1 and `rom_a_m1_oe`=0. Whenever `rom_ce_n` is high, `rom_oe_n` is high too.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. It yields `req_len`+1 elements at consecutive ascending addresses, wrapping at the top of the address space. Each element comes with a one-cycle `rd_valid`, and `rd_last` is high only with the final element.
- R3: The first element of every burst appears on `rd_valid` in the cycle after the L-th clock edge following acceptance, where L = max(`cfg_long_wait`,1). Page history is forgotten in standby, so this holds even when the previous burst ended in the same page.
- R4: A following element whose word address keeps the same bits 3 and up (same 8-word page) appears S = max(`cfg_short_wait`,1) edges after the previous one. An element that enters a new page appears L edges after the previous one.
- R5: In word mode (`req_byte`=0): `rom_byte_n`=1, `rom_addr` equals element address bits [22:0], `rom_a_m1_oe`=0, and `rd_data` is the full 16-bit `rom_dq_in`.
- R6: In byte mode (`req_byte`=1): `rom_byte_n`=0, `rom_a_m1_oe`=1 while the ROM is enabled, `rom_a_m1_out` equals byte address bit 0, `rom_addr` equals byte address bits [23:1], and `rd_data` = {8'h00, `rom_dq_in`[7:0]}. Bits 15..8 of `rom_dq_in` have no effect.
- R7: During a burst `rom_ce_n` and `rom_oe_n` are low, and `rom_addr` and the A-1 pin stay constant for the whole wait of each access.
- R8: In the cycle after the final capture `rom_ce_n` and `rom_oe_n` are high. `req_ready` then stays low for `cfg_turn` cycles and returns high after them.
- R9: The wait and turnaround settings are sampled when a request is accepted. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request strobe |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | 24 | Start element address (word address in bits 22:0, or byte address) |
| req_len | input | 8 | Number of elements minus one |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| cfg_long_wait | input | 5 | Cycles per random (page-miss) access |
| cfg_short_wait | input | 5 | Cycles per in-page access |
| cfg_turn | input | 4 | Standby cycles before the next request |
| rd_valid | output | 1 | Returned element valid |
| rd_last | output | 1 | Returned element is the final one of the burst |
| rd_data | output | 16 | Returned element |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, low for byte mode |
| rom_addr | output | 23 | ROM word address |
| rom_a_m1_out | output | 1 | Value for the shared top data / lowest address pin |
| rom_a_m1_oe | output | 1 | Drive enable for the shared pin |
| rom_dq_in | input | 16 | ROM data bus |

## Verification
The bench uses the default parameters: 23-bit word address, 8-word page and 16-bit data. It runs them mostly with wait counts of 4 and 2 and a turnaround of 3, which keeps each burst short. This makes it affordable to sweep every start offset in a page against burst lengths that cross one or two page boundaries, in both word and byte mode, with every arrival cycle computed from the page arithmetic. Further runs use the default 10/3 counts with zero turnaround, zero-valued waits that must clamp to one cycle, and bursts that wrap past the top of the address space. The ROM model returns inverted data until the address has been held long enough, so any early capture shows up as a data mismatch.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } rd_state_e;

endpackage

// File: rtl/prom_addr_map.sv
// Steers an element address onto the ROM word address and the shared low pin.
module prom_addr_map #(
    parameter int WORD_AW = 23
) (
    input  logic [WORD_AW:0]   elem_addr,
    input  logic               byte_mode,
    output logic [WORD_AW-1:0] word_addr,
    output logic               a_m1
);
    always_comb begin
        if (byte_mode) begin
            word_addr = elem_addr[WORD_AW:1];
            a_m1      = elem_addr[0];
        end else begin
            word_addr = elem_addr[WORD_AW-1:0];
            a_m1      = 1'b0;
        end
    end
endmodule

// File: rtl/prom_page_track.sv
// Remembers the page of the access in flight and reports whether a probe stays in it.
module prom_page_track #(
    parameter int WORD_AW = 23,
    parameter int PAGE_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             commit,
    input  logic [WORD_AW:0] commit_addr,
    input  logic             commit_mode,
    input  logic [WORD_AW:0] probe_addr,
    input  logic             probe_mode,
    output logic             hit
);
    localparam int TAG_W = WORD_AW - PAGE_W;

    function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_AW:0] a, input logic bm);
        return bm ? a[WORD_AW:PAGE_W+1] : a[WORD_AW-1:PAGE_W];
    endfunction

    logic [TAG_W-1:0] last_tag;
    logic             last_mode;
    logic             last_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_tag  <= '0;
            last_mode <= 1'b0;
            last_vld  <= 1'b0;
        end else if (commit) begin
            last_tag  <= tag_of(commit_addr, commit_mode);
            last_mode <= commit_mode;
            last_vld  <= 1'b1;
        end else if (clear) begin
            last_vld  <= 1'b0;
        end
    end

    assign hit = last_vld && (last_mode == probe_mode)
              && (last_tag == tag_of(probe_addr, probe_mode));
endmodule

// File: rtl/prom_wait_ctr.sv
// One-shot access timer: loaded per access, expires after the loaded count (minimum 1).
module prom_wait_ctr #(
    parameter int WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? ONE : load_val;
        end else if (cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = (cnt == ONE);
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
    import prom_pkg::*;
#(
    parameter int WORD_AW = 23,
    parameter int PAGE_W  = 3,
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 8,
    parameter int WAIT_W  = 5,
    parameter int TURN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_AW:0]  req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_byte,
    input  logic [WAIT_W-1:0] cfg_long_wait,
    input  logic [WAIT_W-1:0] cfg_short_wait,
    input  logic [TURN_W-1:0] cfg_turn,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [DATA_W-1:0] rd_data,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_byte_n,
    output logic [WORD_AW-1:0] rom_addr,
    output logic              rom_a_m1_out,
    output logic              rom_a_m1_oe,
    input  logic [DATA_W-1:0] rom_dq_in
);
    localparam int ELEM_AW = WORD_AW + 1;
    localparam int HALF_W  = DATA_W / 2;
    localparam logic [ELEM_AW-1:0] ONE_E = ELEM_AW'(1);
    localparam logic [LEN_W-1:0]   ONE_L = LEN_W'(1);
    localparam logic [TURN_W-1:0]  ONE_T = TURN_W'(1);

    rd_state_e state, state_nxt;

    logic [ELEM_AW-1:0] cur_addr;
    logic [ELEM_AW-1:0] nxt_addr;
    logic [LEN_W-1:0]   left;
    logic               mode_byte;
    logic [WAIT_W-1:0]  lw, sw;
    logic [TURN_W-1:0]  tw, ta_cnt;

    logic [WORD_AW-1:0] cur_wa;
    logic               cur_m1;
    logic               hit;
    logic               expired;
    logic               accept, capture, more;
    logic               ctr_load;
    logic [WAIT_W-1:0]  ctr_val;

    assign accept   = req_valid && (state == ST_IDLE);
    assign capture  = (state == ST_ACCESS) && expired;
    assign more     = (left != '0);
    assign nxt_addr = cur_addr + ONE_E;

    prom_addr_map #(.WORD_AW(WORD_AW)) u_map (
        .elem_addr (cur_addr),
        .byte_mode (mode_byte),
        .word_addr (cur_wa),
        .a_m1      (cur_m1)
    );

    prom_page_track #(.WORD_AW(WORD_AW), .PAGE_W(PAGE_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (state != ST_ACCESS),
        .commit      (accept || (capture && more)),
        .commit_addr (accept ? req_addr : nxt_addr),
        .commit_mode (accept ? req_byte : mode_byte),
        .probe_addr  (nxt_addr),
        .probe_mode  (mode_byte),
        .hit         (hit)
    );

    always_comb begin
        ctr_load = accept || (capture && more);
        if (accept) begin
            ctr_val = cfg_long_wait;
        end else begin
            ctr_val = hit ? sw : lw;
        end
    end

    prom_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .expired  (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nxt = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (capture && !more) begin
                    state_nxt = (tw == '0) ? ST_IDLE : ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (ta_cnt <= ONE_T) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            left      <= '0;
            mode_byte <= 1'b0;
            lw        <= '0;
            sw        <= '0;
            tw        <= '0;
            ta_cnt    <= '0;
            rd_valid  <= 1'b0;
            rd_last   <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            if (accept) begin
                cur_addr  <= req_addr;
                left      <= req_len;
                mode_byte <= req_byte;
                lw        <= cfg_long_wait;
                sw        <= cfg_short_wait;
                tw        <= cfg_turn;
            end
            if (capture) begin
                rd_valid <= 1'b1;
                rd_last  <= !more;
                rd_data  <= mode_byte ? {{(DATA_W-HALF_W){1'b0}}, rom_dq_in[HALF_W-1:0]}
                                      : rom_dq_in;
                if (more) begin
                    cur_addr <= nxt_addr;
                    left     <= left - ONE_L;
                end
            end
            if (state == ST_ACCESS && state_nxt == ST_RELEASE) begin
                ta_cnt <= tw;
            end else if (state == ST_RELEASE) begin
                ta_cnt <= ta_cnt - ONE_T;
            end
        end
    end

    // pin and handshake outputs
    always_comb begin
        req_ready    = (state == ST_IDLE);
        rom_ce_n     = (state != ST_ACCESS);
        rom_oe_n     = (state != ST_ACCESS);
        rom_byte_n   = !mode_byte;
        rom_addr     = cur_wa;
        rom_a_m1_out = mode_byte && cur_m1;
        rom_a_m1_oe  = mode_byte && (state == ST_ACCESS);
    end
endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk #(
    parameter int WORD_AW = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               rd_valid,
    input logic               rd_last,
    input logic               rom_ce_n,
    input logic               rom_oe_n,
    input logic               rom_byte_n,
    input logic               rom_a_m1_out,
    input logic               rom_a_m1_oe,
    input logic [WORD_AW-1:0] rom_addr
);
    // R1
    standby_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> rom_oe_n);

    // R2
    last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R5
    word_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_byte_n |-> !rom_a_m1_oe);

    // R6
    byte_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_byte_n && !rom_ce_n) |-> rom_a_m1_oe);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && $past(!rom_ce_n) && !rd_valid) |-> ($stable(rom_addr) && $stable(rom_a_m1_out)));

    // R8
    ready_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rom_ce_n && rom_oe_n));
endmodule

bind prom_page_reader prom_page_reader_chk #(.WORD_AW(WORD_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rd_valid     (rd_valid),
    .rd_last      (rd_last),
    .rom_ce_n     (rom_ce_n),
    .rom_oe_n     (rom_oe_n),
    .rom_byte_n   (rom_byte_n),
    .rom_a_m1_out (rom_a_m1_out),
    .rom_a_m1_oe  (rom_a_m1_oe),
    .rom_addr     (rom_addr)
);

// File: tb/prom_page_reader_tb.sv
`timescale 1ns/1ps
module prom_page_reader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_byte = 1'b0;
    logic [4:0]  cfg_long_wait = 5'd4;
    logic [4:0]  cfg_short_wait = 5'd2;
    logic [3:0]  cfg_turn = 4'd3;
    logic        rd_valid, rd_last;
    logic [15:0] rd_data;
    logic        rom_ce_n, rom_oe_n, rom_byte_n;
    logic [22:0] rom_addr;
    logic        rom_a_m1_out, rom_a_m1_oe;
    logic [15:0] rom_dq_in;

    int n_chk = 0;
    int n_bad = 0;
    int e_l = 4, e_s = 2, e_t = 3;
    logic [4:0] k_l = 5'd4, k_s = 5'd2;
    logic [3:0] k_t = 4'd3;

    always #2.5 clk = ~clk;

    prom_page_reader u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
        .cfg_long_wait(cfg_long_wait), .cfg_short_wait(cfg_short_wait), .cfg_turn(cfg_turn),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data),
        .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n),
        .rom_addr(rom_addr), .rom_a_m1_out(rom_a_m1_out), .rom_a_m1_oe(rom_a_m1_oe),
        .rom_dq_in(rom_dq_in)
    );

    function automatic logic [15:0] rom_word(input logic [22:0] w);
        return w[15:0] ^ {w[22:16], w[22:14]} ^ 16'hA53C;
    endfunction

    // ROM model: data inverted until the address has been held for the needed cycles
    logic [22:0] m_w = '0;
    logic        m_m1 = 1'b0, m_bm = 1'b0, m_act = 1'b0;
    int          m_cnt = 0, m_need = 1;
    logic        act, same, hitp, good;
    int          k_now, need_now;
    logic [15:0] wv;
    logic [7:0]  sel;

    always_comb begin
        act  = !rom_ce_n && !rom_oe_n;
        same = m_act && act && (m_w == rom_addr) && (m_bm == !rom_byte_n)
               && (rom_byte_n || (m_m1 == rom_a_m1_out));
        hitp = m_act && act && (m_bm == !rom_byte_n) && (m_w[22:3] == rom_addr[22:3]);
        k_now    = same ? m_cnt + 1 : 1;
        need_now = same ? m_need : (hitp ? e_s : e_l);
        good = act && (k_now >= need_now);
        wv   = rom_word(rom_addr);
        sel  = rom_a_m1_out ? wv[15:8] : wv[7:0];
        if (!rom_byte_n) rom_dq_in = {1'b0, 7'h55, good ? sel : ~sel};
        else             rom_dq_in = good ? wv : ~wv;
    end

    always @(posedge clk) begin
        m_act  <= act;
        m_w    <= rom_addr;
        m_m1   <= rom_a_m1_out;
        m_bm   <= !rom_byte_n;
        m_cnt  <= k_now;
        m_need <= need_now;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] actv, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
        end
    endtask

    task automatic set_cfg(input int l, input int s, input int t);
        k_l = 5'(l); k_s = 5'(s); k_t = 4'(t);
        cfg_long_wait = k_l; cfg_short_wait = k_s; cfg_turn = k_t;
        e_l = (l == 0) ? 1 : l;
        e_s = (s == 0) ? 1 : s;
        e_t = t;
    endtask

    function automatic logic [19:0] pg(input logic [23:0] a, input bit bm);
        return bm ? a[23:4] : a[22:3];
    endfunction

    task automatic run_burst(input logic [23:0] a, input int n, input bit bm);
        int idx, tdue, prev_idx, guard;
        logic [23:0] ea;
        logic [22:0] ewa;
        logic [15:0] w, exp_d;
        guard = 0;
        while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_addr = a; req_len = 8'(n - 1); req_byte = bm;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: scramble the settings while the burst runs
        cfg_long_wait = 5'd29; cfg_short_wait = 5'd13; cfg_turn = 4'd11;
        idx = 1; tdue = e_l; ea = a; prev_idx = 0;
        for (int k = 0; k < n; k++) begin
            ewa = bm ? ea[23:1] : ea[22:0];
            while (idx < tdue + 1) begin
                if (idx == tdue) begin
                    chk(!rom_ce_n && !rom_oe_n, "R7 enables", {30'd0, rom_ce_n, rom_oe_n}, 32'd0);
                    chk(rom_addr == ewa, "R7 rom_addr", {9'd0, rom_addr}, {9'd0, ewa});
                    if (bm) chk(!rom_byte_n && rom_a_m1_oe && (rom_a_m1_out == ea[0]), "R6 pins",
                                {29'd0, rom_byte_n, rom_a_m1_oe, rom_a_m1_out}, {30'd1, ea[0]});
                    else    chk(rom_byte_n && !rom_a_m1_oe, "R5 pins",
                                {30'd0, rom_byte_n, rom_a_m1_oe}, 32'd2);
                end
                if (idx != prev_idx)
                    chk(!rd_valid, (k == 0) ? "R3 early" : "R4 early", {31'd0, rd_valid}, 32'd0);
                @(negedge clk); idx++;
            end
            w = rom_word(ewa);
            exp_d = bm ? {8'h00, ea[0] ? w[15:8] : w[7:0]} : w;
            chk(rd_valid, (k == 0) ? "R3 arrival" : "R4 arrival", {31'd0, rd_valid}, 32'd1);
            chk(rd_data == exp_d, bm ? "R6 data" : "R5 data", {16'd0, rd_data}, {16'd0, exp_d});
            chk(rd_last == (k == n - 1), "R2 last", {31'd0, rd_last}, {31'd0, k == n - 1});
            prev_idx = idx;
            tdue = tdue + ((pg(ea + 24'd1, bm) != pg(ea, bm)) ? e_l : e_s);
            ea = ea + 24'd1;
        end
        chk(rom_ce_n && rom_oe_n, "R8 standby", {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
        for (int j = 0; j <= e_t; j++) begin
            chk(req_ready == (j == e_t), "R8 turnaround", {31'd0, req_ready}, {31'd0, j == e_t});
            if (j < e_t) @(negedge clk);
        end
        cfg_long_wait = k_l; cfg_short_wait = k_s; cfg_turn = k_t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(rom_ce_n && rom_oe_n && req_ready && !rd_valid && rom_byte_n && !rom_a_m1_oe,
            "R1 reset", {26'd0, rom_ce_n, rom_oe_n, req_ready, rd_valid, rom_byte_n, rom_a_m1_oe},
            32'b111010);

        set_cfg(4, 2, 3);
        for (int off = 0; off < 8; off++)
            for (int len = 1; len <= 10; len++)
                run_burst(24'(40 + off), len, 1'b0);
        for (int off = 0; off < 16; off++)
            for (int len = 1; len <= 18; len++)
                run_burst(24'(320 + off), len, 1'b1);

        set_cfg(10, 3, 0);
        run_burst(24'h000005, 12, 1'b0);
        run_burst(24'h000005, 4, 1'b0);
        run_burst(24'h00001C, 10, 1'b1);

        set_cfg(0, 0, 1);
        run_burst(24'h000000, 9, 1'b0);
        run_burst(24'h00000E, 5, 1'b1);

        set_cfg(4, 2, 2);
        run_burst(24'h7FFFFD, 6, 1'b0);
        run_burst(24'hFFFFFE, 4, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule